// File: doc/BRIEF.md
# Ethernet Receive Packet Monitor

This block observes the receive side of an Ethernet MAC through a 32-bit packet stream. For every frame it computes CRC-32 over all bytes, including the trailing frame check sequence, and judges the frame by comparing the final remainder with the fixed Ethernet residue. A frame is also judged bad when the MAC reports a nonzero error code on its last beat. Good and bad frames are counted separately. A 64-bit byte counter and a 64-bit cycle counter provide the raw figures for a throughput measurement.

Software controls the block through a small 32-bit register port with an expected-frame count and a control/status word. START begins a run and STOP ends it. The run also ends by itself once the number of judged frames reaches the expected count. The counters then freeze and a done flag is raised. Each 64-bit counter is read as two words, and a shadow register keeps the pair consistent.

The stream sink never applies back-pressure: `snk_ready` is held high, so every cycle with `snk_valid` high is an accepted beat. The source must not depend on stalling. The register read data appears one cycle after the read strobe.

Top module: `rx_packet_monitor`

## Requirements
- R1: `snk_ready` is always 1, and a beat is accepted on any cycle where `snk_valid` is 1. The first byte of a beat is in `snk_data[31:24]` and the following bytes are in lower lanes. On an end-of-packet beat, `snk_empty` gives the number of unused bytes at the low end.
- R2: A frame is good when both of these hold:
  - CRC-32 run over all of its bytes, with the check sequence sent least significant byte first, leaves the unreflected remainder 0xC704DD7B.
  - `snk_err` is zero on its end-of-packet beat.
  Any other frame is bad.
- R3: Each frame counted in a run adds one to exactly one counter: good frames (word 1, byte offset 0x04) or bad frames (word 2, byte offset 0x08).
- R4: The byte counter adds 4 for each accepted beat of a counted frame, or 4 minus `snk_empty` on the end-of-packet beat. A run's total therefore equals the sum of its frame lengths.
- R5: The cycle counter counts every clock cycle in a run. Counting starts at the first accepted start-of-packet after START. It ends with the end-of-packet beat that completes the run, or with STOP, and does not move outside a run.
- R6: When good plus bad frames reaches the expected count (word 0, byte offset 0x00), done is set (control bit 2). The run then ends and no counter changes until the next START.
- R7: Writing 1 to control bit 0 (START) does all of the following:
  - clears both frame counters, the byte and cycle counters, done, the CRC flag, the error field and the stop flag;
  - begins a run.
  Bit 0 always reads 0.
- R8: Writing 1 to control bit 1 (STOP) ends the run, and later frames are ignored. Bit 1 reads 1 until the next START. If START and STOP are written together, the counters are cleared and no run begins.
- R9: Control bit 3 holds the CRC failure of the last counted frame. Bits 9:4 hold the `snk_err` value on that frame's end-of-packet beat.
- R10: The byte counter is read at words 3 and 4 (offsets 0x0C and 0x10), low half then high half. The cycle counter is read at words 5 and 6 (offsets 0x14 and 0x18), low half then high half. Reading a low half copies the matching high half into a shadow register. A later read of the high half returns that shadow.
- R11: A frame whose start-of-packet arrives while no run is active changes no counter.
- R12: After reset, every register reads zero. The control/status register is word 7 (offset 0x1C).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| snk_valid | input | 1 | Stream beat valid |
| snk_ready | output | 1 | Stream ready, constant 1 |
| snk_data | input | 32 | Beat data, first byte in bits 31:24 |
| snk_sop | input | 1 | First beat of frame |
| snk_eop | input | 1 | Last beat of frame |
| snk_empty | input | 2 | Unused low bytes on last beat |
| snk_err | input | 6 | MAC receive error code |
| csr_word | input | 3 | Register word address (byte offset / 4) |
| csr_write | input | 1 | Register write strobe |
| csr_read | input | 1 | Register read strobe |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, valid the cycle after the strobe |

## Verification
The hardest situation to reach is a read of a split counter while a carry passes from the low half into the high half. With 32-bit halves this needs billions of bytes. The bench therefore builds the block with 8-bit counter halves. It streams back-to-back frames in one process while a second process reads the byte counter over and over. Every low/high pair must form a value that does not decrease and that moves forward by no more than the traffic between reads, so a torn pair shows up as a jump of 256.

// File: rtl/rxmon_pkg.sv
package rxmon_pkg;

  // CRC remainder expected after a whole frame, check sequence included
  localparam logic [31:0] CRC_RESIDUE   = 32'hC704DD7B;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  typedef enum logic [2:0] {
    REG_EXPECT  = 3'd0,
    REG_GOOD    = 3'd1,
    REG_BAD     = 3'd2,
    REG_BYTE_LO = 3'd3,
    REG_BYTE_HI = 3'd4,
    REG_CYC_LO  = 3'd5,
    REG_CYC_HI  = 3'd6,
    REG_CTRL    = 3'd7
  } reg_sel_e;

  // one byte through the reflected CRC-32 register, least significant bit first
  function automatic logic [31:0] crc_byte(input logic [31:0] c_in, input logic [7:0] b);
    logic [31:0] c;
    c = c_in ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction

  function automatic logic [31:0] bit_rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int k = 0; k < 32; k++) r[k] = v[31-k];
    return r;
  endfunction

endpackage

// File: rtl/rxmon_crc.sv
module rxmon_crc
  import rxmon_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ERR_W  = 6,
  localparam int LANES   = DATA_W / 8,
  localparam int EMPTY_W = $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               beat,
  input  logic               sop,
  input  logic               eop,
  input  logic [DATA_W-1:0]  data,
  input  logic [EMPTY_W-1:0] empty,
  input  logic [ERR_W-1:0]   err,
  output logic               crc_fail,
  output logic               frame_bad
);

  logic [31:0] crc_q;
  logic [31:0] crc_nxt;

  always_comb begin
    crc_nxt = sop ? 32'hFFFF_FFFF : crc_q;
    for (int i = 0; i < LANES; i++) begin
      if (!eop || (i < (LANES - int'(empty))))
        crc_nxt = crc_byte(crc_nxt, data[DATA_W-1-8*i -: 8]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    crc_q <= 32'hFFFF_FFFF;
    else if (beat) crc_q <= crc_nxt;
  end

  // meaningful on the end-of-packet beat only
  assign crc_fail  = (bit_rev32(crc_nxt) != CRC_RESIDUE);
  assign frame_bad = crc_fail || (err != '0);

endmodule

// File: rtl/rxmon_stats.sv
module rxmon_stats #(
  parameter int HALF_W = 32,
  parameter int LANES  = 4,
  parameter int ERR_W  = 6,
  localparam int CW      = 2 * HALF_W,
  localparam int EMPTY_W = $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               beat,
  input  logic               sop,
  input  logic               eop,
  input  logic [EMPTY_W-1:0] empty,
  input  logic [ERR_W-1:0]   err,
  input  logic               crc_fail,
  input  logic               frame_bad,
  input  logic               start_req,
  input  logic               stop_req,
  input  logic [31:0]        expect_cnt,
  output logic [31:0]        good_cnt,
  output logic [31:0]        bad_cnt,
  output logic [CW-1:0]      byte_cnt,
  output logic [CW-1:0]      cyc_cnt,
  output logic               done,
  output logic               stopped,
  output logic               crcbad,
  output logic [ERR_W-1:0]   err_lat
);

  logic running, track, timing;
  logic live, accept, end_cnt, hit, cyc_en;
  logic [CW-1:0] add_bytes;

  assign live      = running && !stop_req;
  assign accept    = live && beat && (sop || track);
  assign end_cnt   = accept && eop;
  assign hit       = end_cnt && ((good_cnt + bad_cnt + 32'd1) == expect_cnt);
  assign cyc_en    = live && (timing || (beat && sop));
  assign add_bytes = eop ? CW'(LANES - int'(empty)) : CW'(LANES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0; track <= 1'b0; timing <= 1'b0;
      good_cnt <= '0; bad_cnt <= '0; byte_cnt <= '0; cyc_cnt <= '0;
      done <= 1'b0; stopped <= 1'b0; crcbad <= 1'b0; err_lat <= '0;
    end else if (start_req) begin
      running <= !stop_req; stopped <= stop_req;
      track <= 1'b0; timing <= 1'b0;
      good_cnt <= '0; bad_cnt <= '0; byte_cnt <= '0; cyc_cnt <= '0;
      done <= 1'b0; crcbad <= 1'b0; err_lat <= '0;
    end else begin
      if (stop_req) begin
        running <= 1'b0; stopped <= 1'b0 | 1'b1;
        track <= 1'b0; timing <= 1'b0;
      end
      if (cyc_en) begin
        cyc_cnt <= cyc_cnt + CW'(1);
        timing  <= 1'b1;
      end
      if (accept) begin
        byte_cnt <= byte_cnt + add_bytes;
        track    <= !eop;
      end
      if (end_cnt) begin
        if (frame_bad) bad_cnt  <= bad_cnt + 32'd1;
        else           good_cnt <= good_cnt + 32'd1;
        crcbad  <= crc_fail;
        err_lat <= err;
      end
      if (hit) begin
        done    <= 1'b1;
        running <= 1'b0;
        timing  <= 1'b0;
      end
    end
  end

  assert_one_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (end_cnt && !start_req) |=> ((good_cnt + bad_cnt) == ($past(good_cnt + bad_cnt) + 32'd1)));

  assert_done_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ((good_cnt + bad_cnt) == expect_cnt));

  assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start_req) |=> ($stable(byte_cnt) && $stable(cyc_cnt) && $stable(good_cnt)));

  assert_start_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> (byte_cnt == '0 && cyc_cnt == '0 && good_cnt == '0 && bad_cnt == '0 && !done));

  assert_idle_cycles_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start_req) |=> $stable(cyc_cnt));

endmodule

// File: rtl/rxmon_csr.sv
module rxmon_csr
  import rxmon_pkg::*;
#(
  parameter int HALF_W = 32,
  parameter int ERR_W  = 6,
  localparam int CW = 2 * HALF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       word,
  input  logic             wr,
  input  logic             rd,
  input  logic [31:0]      wdata,
  input  logic [31:0]      good_cnt,
  input  logic [31:0]      bad_cnt,
  input  logic [CW-1:0]    byte_cnt,
  input  logic [CW-1:0]    cyc_cnt,
  input  logic             done,
  input  logic             stopped,
  input  logic             crcbad,
  input  logic [ERR_W-1:0] err_lat,
  output logic [31:0]      rdata,
  output logic [31:0]      expect_cnt,
  output logic             start_req,
  output logic             stop_req
);

  reg_sel_e sel;
  logic [HALF_W-1:0] byte_hi_sh, cyc_hi_sh;

  assign sel       = reg_sel_e'(word);
  assign start_req = wr && (sel == REG_CTRL) && wdata[0];
  assign stop_req  = wr && (sel == REG_CTRL) && wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      expect_cnt <= '0; byte_hi_sh <= '0; cyc_hi_sh <= '0; rdata <= '0;
    end else begin
      if (wr && sel == REG_EXPECT) expect_cnt <= wdata;
      if (rd) begin
        case (sel)
          REG_EXPECT:  rdata <= expect_cnt;
          REG_GOOD:    rdata <= good_cnt;
          REG_BAD:     rdata <= bad_cnt;
          REG_BYTE_LO: begin
            rdata      <= 32'(byte_cnt[HALF_W-1:0]);
            byte_hi_sh <= byte_cnt[CW-1:HALF_W];
          end
          REG_BYTE_HI: rdata <= 32'(byte_hi_sh);
          REG_CYC_LO:  begin
            rdata     <= 32'(cyc_cnt[HALF_W-1:0]);
            cyc_hi_sh <= cyc_cnt[CW-1:HALF_W];
          end
          REG_CYC_HI:  rdata <= 32'(cyc_hi_sh);
          default:     rdata <= 32'({err_lat, crcbad, done, stopped, 1'b0});
        endcase
      end
    end
  end

  assert_shadow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == REG_BYTE_LO) |=> (byte_hi_sh == $past(byte_cnt[CW-1:HALF_W])));

endmodule

// File: rtl/rx_packet_monitor.sv
module rx_packet_monitor #(
  parameter int HALF_W = 32,
  parameter int DATA_W = 32,
  parameter int ERR_W  = 6,
  localparam int LANES   = DATA_W / 8,
  localparam int EMPTY_W = $clog2(LANES),
  localparam int CW      = 2 * HALF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               snk_valid,
  output logic               snk_ready,
  input  logic [DATA_W-1:0]  snk_data,
  input  logic               snk_sop,
  input  logic               snk_eop,
  input  logic [EMPTY_W-1:0] snk_empty,
  input  logic [ERR_W-1:0]   snk_err,
  input  logic [2:0]         csr_word,
  input  logic               csr_write,
  input  logic               csr_read,
  input  logic [31:0]        csr_wdata,
  output logic [31:0]        csr_rdata
);

  logic crc_fail, frame_bad, start_req, stop_req;
  logic done, stopped, crcbad;
  logic [ERR_W-1:0] err_lat;
  logic [31:0] expect_cnt, good_cnt, bad_cnt;
  logic [CW-1:0] byte_cnt, cyc_cnt;

  assign snk_ready = 1'b1;

  rxmon_crc #(.DATA_W(DATA_W), .ERR_W(ERR_W)) u_crc (
    .clk(clk), .rst_n(rst_n), .beat(snk_valid), .sop(snk_sop), .eop(snk_eop),
    .data(snk_data), .empty(snk_empty), .err(snk_err),
    .crc_fail(crc_fail), .frame_bad(frame_bad)
  );

  rxmon_stats #(.HALF_W(HALF_W), .LANES(LANES), .ERR_W(ERR_W)) u_stats (
    .clk(clk), .rst_n(rst_n), .beat(snk_valid), .sop(snk_sop), .eop(snk_eop),
    .empty(snk_empty), .err(snk_err), .crc_fail(crc_fail), .frame_bad(frame_bad),
    .start_req(start_req), .stop_req(stop_req), .expect_cnt(expect_cnt),
    .good_cnt(good_cnt), .bad_cnt(bad_cnt), .byte_cnt(byte_cnt), .cyc_cnt(cyc_cnt),
    .done(done), .stopped(stopped), .crcbad(crcbad), .err_lat(err_lat)
  );

  rxmon_csr #(.HALF_W(HALF_W), .ERR_W(ERR_W)) u_csr (
    .clk(clk), .rst_n(rst_n), .word(csr_word), .wr(csr_write), .rd(csr_read),
    .wdata(csr_wdata), .good_cnt(good_cnt), .bad_cnt(bad_cnt),
    .byte_cnt(byte_cnt), .cyc_cnt(cyc_cnt), .done(done), .stopped(stopped),
    .crcbad(crcbad), .err_lat(err_lat), .rdata(csr_rdata),
    .expect_cnt(expect_cnt), .start_req(start_req), .stop_req(stop_req)
  );

endmodule

// File: tb/sim_rx_packet_monitor.sv
module sim_rx_packet_monitor;
  localparam int HW = 8;

  logic clk = 0, rst_n = 0;
  logic snk_valid = 0, snk_sop = 0, snk_eop = 0;
  logic snk_ready;
  logic [31:0] snk_data = '0;
  logic [1:0] snk_empty = '0;
  logic [5:0] snk_err = '0;
  logic [2:0] csr_word = '0;
  logic csr_write = 0, csr_read = 0;
  logic [31:0] csr_wdata = '0, csr_rdata;

  int checks = 0, errors = 0;
  logic [7:0] fb [0:63];
  int flen;
  logic arm = 0, last_frame = 0, span_on = 0, span_done = 0;
  int span_cnt = 0;

  always #10 clk = ~clk;

  rx_packet_monitor #(.HALF_W(HW)) u0 (
    .clk(clk), .rst_n(rst_n), .snk_valid(snk_valid), .snk_ready(snk_ready),
    .snk_data(snk_data), .snk_sop(snk_sop), .snk_eop(snk_eop), .snk_empty(snk_empty),
    .snk_err(snk_err), .csr_word(csr_word), .csr_write(csr_write), .csr_read(csr_read),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata)
  );

  // cycle span of a run, measured at the ports
  always @(posedge clk) begin
    if (arm && !span_on && !span_done && snk_valid && snk_sop) span_on = 1;
    if (span_on) span_cnt++;
    if (span_on && snk_valid && snk_eop && last_frame) begin span_on = 0; span_done = 1; end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [2:0] w, input logic [31:0] d);
    @(negedge clk); csr_word = w; csr_wdata = d; csr_write = 1;
    @(negedge clk); csr_write = 0;
  endtask

  task automatic csr_rd(input logic [2:0] w, output logic [31:0] d);
    @(negedge clk); csr_word = w; csr_read = 1;
    @(negedge clk); csr_read = 0; d = csr_rdata;
  endtask

  task automatic rd64(input logic [2:0] lo_w, output longint v);
    logic [31:0] lo, hi;
    csr_rd(lo_w, lo);
    csr_rd(lo_w + 3'd1, hi);
    v = longint'(hi) * 256 + longint'(lo);
  endtask

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      c ^= {24'd0, fb[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic build(input int plen, input int seed);
    logic [31:0] f;
    for (int i = 0; i < plen; i++) fb[i] = 8'((seed * 37 + i * 11 + 5) & 255);
    f = ref_crc(plen);
    for (int i = 0; i < 4; i++) fb[plen + i] = f[8*i +: 8];
    flen = plen + 4;
  endtask

  task automatic send(input int flip, input logic [5:0] e, input int gap, input logic last);
    int beats;
    if (flip >= 0) fb[flip / 8] ^= 8'(1 << (flip % 8));
    beats = (flen + 3) / 4;
    for (int b = 0; b < beats; b++) begin
      @(negedge clk);
      snk_valid = 1; snk_sop = (b == 0); snk_eop = (b == beats - 1);
      snk_empty = snk_eop ? 2'(beats * 4 - flen) : 2'd0;
      snk_err = snk_eop ? e : 6'd0;
      last_frame = snk_eop && last;
      for (int k = 0; k < 4; k++)
        snk_data[31 - 8*k -: 8] = (b * 4 + k < flen) ? fb[b * 4 + k] : 8'h00;
    end
    @(negedge clk);
    snk_valid = 0; snk_sop = 0; snk_eop = 0; snk_err = 0; last_frame = 0;
    for (int g = 0; g < gap; g++) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    longint v, prev;
    int exp_good = 0, exp_bad = 0;
    longint exp_bytes = 0, c1, c2;

    repeat (3) @(negedge clk);
    rst_n = 1;

    // R12 / R1: reset state and constant ready
    chk("R1 ready", longint'(snk_ready), 1);
    for (int w = 0; w < 8; w++) begin
      csr_rd(3'(w), d);
      chk("R12 reset value", longint'(d), 0);
    end

    // R11: traffic before any START is ignored
    build(8, 1); send(-1, 0, 0, 0);
    csr_rd(3'd1, d); chk("R11 good untouched", longint'(d), 0);
    csr_rd(3'd3, d); chk("R11 bytes untouched", longint'(d), 0);

    // Main sweep: all lengths giving every empty value, good / CRC-bad / MAC-error frames
    csr_wr(3'd0, 32'd36);
    csr_wr(3'd7, 32'd1);
    arm = 1;
    for (int plen = 1; plen <= 12; plen++) begin
      for (int kind = 0; kind < 3; kind++) begin
        logic [5:0] e;
        logic lastf;
        e = (kind == 2) ? 6'(plen) : 6'd0;
        lastf = (plen == 12 && kind == 2);
        build(plen, plen * 3 + kind);
        send((kind == 1) ? (plen * 5 + kind) % (flen * 8) : -1, e, plen % 3, lastf);
        if (kind == 0) exp_good++; else exp_bad++;
        exp_bytes += flen;
        csr_rd(3'd7, d);
        chk("R2 R9 crc flag", longint'(d[3]), (kind == 1) ? 1 : 0);
        chk("R9 error field", longint'(d[9:4]), longint'(e));
        chk("R6 done flag", longint'(d[2]), lastf ? 1 : 0);
      end
    end
    csr_rd(3'd1, d); chk("R3 good count", longint'(d), exp_good);
    csr_rd(3'd2, d); chk("R3 bad count", longint'(d), exp_bad);
    rd64(3'd3, v);   chk("R4 byte count", v, exp_bytes);
    rd64(3'd5, v);   chk("R5 cycle count", v, span_cnt);
    csr_rd(3'd0, d); chk("R6 expected readback", longint'(d), 36);

    // R6: after done, traffic changes nothing
    build(6, 99); send(-1, 0, 1, 0);
    csr_rd(3'd1, d); chk("R6 good frozen", longint'(d), exp_good);
    rd64(3'd3, v);   chk("R6 bytes frozen", v, exp_bytes);

    // R8: STOP ends the run
    csr_wr(3'd0, 32'd10);
    csr_wr(3'd7, 32'd1);
    csr_rd(3'd7, d);
    chk("R7 start reads zero, flags cleared", longint'(d), 0);
    csr_rd(3'd1, d); chk("R7 good cleared", longint'(d), 0);
    rd64(3'd3, v);   chk("R7 bytes cleared", v, 0);
    build(5, 7); send(-1, 0, 0, 0);
    build(9, 8); send(-1, 0, 0, 0);
    csr_wr(3'd7, 32'd2);
    build(4, 9); send(-1, 0, 0, 0);
    csr_rd(3'd1, d); chk("R8 good after stop", longint'(d), 2);
    csr_rd(3'd7, d);
    chk("R8 stop flag", longint'(d[1]), 1);
    chk("R8 not done", longint'(d[2]), 0);
    rd64(3'd5, c1);
    repeat (5) @(negedge clk);
    rd64(3'd5, c2);
    chk("R5 cycles idle after stop", c2, c1);

    // R8: START and STOP together
    csr_wr(3'd7, 32'd3);
    build(7, 3); send(-1, 0, 0, 0);
    csr_rd(3'd1, d); chk("R8 start+stop no run", longint'(d), 0);
    csr_rd(3'd7, d); chk("R8 start+stop flag", longint'(d[1]), 1);

    // R10: coherent split reads while the low half keeps carrying
    csr_wr(3'd0, 32'd0);
    csr_wr(3'd7, 32'd1);
    csr_rd(3'd7, d); chk("R7 stop flag cleared", longint'(d[1]), 0);
    prev = 0;
    fork
      begin
        for (int n = 0; n < 60; n++) begin build(12, n); send(-1, 0, 0, 0); end
      end
      begin
        for (int n = 0; n < 50; n++) begin
          rd64(3'd3, v);
          chk("R10 pair not behind", (v >= prev) ? 1 : 0, 1);
          chk("R10 pair not ahead", (v - prev <= 24) ? 1 : 0, 1);
          prev = v;
        end
      end
    join
    rd64(3'd3, v); chk("R4 R10 final byte total", v, 60 * 16);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule